// File: doc/BRIEF.md
# Keyed Watchdog Timer with Two-Stage Expiry

This block is a watchdog timer on a 32-bit register bus. It counts a slow tick input, nominally 32.768 kHz, supplied as a one-cycle enable pulse in the bus clock domain. Software programs a timeout length and enables the counter. From then on it must write a restart code before the count runs out. If it does not, the block drives a system reset pulse. The same pulse can also appear on an external reset pin whose polarity is programmable. In two-stage mode with the interrupt enabled, the first expiry does not reset. It raises an interrupt and starts a second full period. The reset follows only if that second period also ends without a restart.

Each register accepts a write only when the written word carries that register's key; a write without the key changes nothing. A software-reset register fires the reset pulse on demand. A sub-reset register drives a bank of reset lines to other logic. When the reset pulse ends, the block's own registers return to their power-on values and the counter is left stopped.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the mode register reads 0, the length register reads `(LEN_RST<<5)|8`, the sub-reset register reads 0, irq and sys_rst are 0, and ext_rst is 1. With the counter disabled, ticks never cause a reset.
- R2: The mode register is at offset 0x00. A write takes effect only when bits [31:24] are 0x22. The stored mode fields are:
  - bit0: enable.
  - bit1: external polarity, where 1 means active high.
  - bit2: external reset enable.
  - bit3: interrupt enable.
  - bit4: auto-start. It is stored only.
  - bit6: two-stage mode.
  - bit8: source select. It is stored only.
  - All other bits read 0.
- R3: The length register is at offset 0x04. A write is accepted only when bits [4:0] are 0x08. The length sits in bits [LEN_W+4:5]. Reads return the length at that position with 0x08 in the low bits. Writing the length does not reload a running count.
- R4: Starting from a 0-to-1 change of the enable bit, or from a restart write, a single-stage count asserts sys_rst on the L·2^UNIT_LOG-th tick, where L is the programmed length.
- R5: Writing exactly 0x1971 to offset 0x08 reloads the count and clears the first-stage state. Any other value written there has no effect.
- R6: With two-stage mode and interrupt enable both set, the first expiry raises irq and reloads the count. If no restart comes, sys_rst follows L·2^UNIT_LOG ticks later.
- R7: irq is a level. It stays high until a restart write or until the interrupt-enable bit is cleared. In the second case the next expiry resets.
- R8: Writing exactly 0x1209 to offset 0x14 asserts sys_rst at the next clock edge. Other values do nothing.
- R9: The reset pulse lasts exactly HOLD ticks. Bus writes are ignored while it lasts. At its end, mode, length and sub-reset return to their reset values.
- R10: While sys_rst is high and mode bit2 is set, ext_rst equals mode bit1. Otherwise ext_rst is the inverse of mode bit1.
- R11: The sub-reset register is at offset 0x18. A write is accepted only when bits [31:24] are 0x88. Bit i drives sub_rst[i] (1 = asserted), and reads return the current bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per slow-clock period |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data including key |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | First-stage expiry interrupt |
| sys_rst | output | 1 | System reset pulse, active high |
| ext_rst | output | 1 | External reset pin, programmable polarity |
| sub_rst | output | NSUB | Software-driven sub-reset lines |

## Verification
The hardest case to reach is the second-stage expiry after the interrupt enable has been dropped mid-flight. Getting there needs a first expiry, then a restart to prove the interrupt clears, then another expiry, and then a mode write that keeps the enable bit set while clearing interrupt enable, so the count is not reloaded. The bench builds this path from bus writes and counted ticks alone, with a short unit of four ticks. It sweeps the length over many values so that each expiry lands on a tick number computed as length times four.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int LEN_W    = 11,
  parameter int UNIT_LOG = 9,
  parameter int HOLD     = 32,
  parameter int NSUB     = 16,
  parameter int LEN_RST  = 1984
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq,
  output logic            sys_rst,
  output logic            ext_rst,
  output logic [NSUB-1:0] sub_rst
);
  localparam int CW = LEN_W + UNIT_LOG;
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [8:0] MODE_MASK = 9'h15F;

  logic [8:0]      mode;
  logic [LEN_W-1:0] len;
  logic [NSUB-1:0] sub;
  logic [CW-1:0]   cnt;
  logic [HW-1:0]   hold;
  logic            stage, pulse;

  logic wr_mode, wr_len, wr_kick, wr_sw, wr_sub;
  logic start, load, expire, first, fire;
  logic [CW-1:0] reload;

  assign wr_mode = bus_we && !pulse && bus_addr == 8'h00 && bus_wdata[31:24] == 8'h22;
  assign wr_len  = bus_we && !pulse && bus_addr == 8'h04 && bus_wdata[4:0] == 5'h08;
  assign wr_kick = bus_we && !pulse && bus_addr == 8'h08 && bus_wdata == 32'h0000_1971;
  assign wr_sw   = bus_we && !pulse && bus_addr == 8'h14 && bus_wdata == 32'h0000_1209;
  assign wr_sub  = bus_we && !pulse && bus_addr == 8'h18 && bus_wdata[31:24] == 8'h88;

  assign reload = {len, {UNIT_LOG{1'b0}}};
  assign start  = wr_mode && bus_wdata[0] && !mode[0];
  assign load   = start || wr_kick;
  assign expire = mode[0] && tick && !pulse && !load && cnt <= CW'(1);
  assign first  = expire && mode[6] && mode[3] && !stage;
  assign fire   = (expire && !first) || wr_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      len   <= LEN_W'(LEN_RST);
      sub   <= '0;
      cnt   <= '0;
      stage <= 1'b0;
      pulse <= 1'b0;
      hold  <= '0;
    end else if (pulse) begin
      if (tick) begin
        if (hold == HW'(HOLD - 1)) begin
          pulse <= 1'b0;
          mode  <= '0;
          len   <= LEN_W'(LEN_RST);
          sub   <= '0;
          cnt   <= '0;
          stage <= 1'b0;
        end else begin
          hold <= hold + 1'b1;
        end
      end
    end else begin
      if (wr_mode) mode <= bus_wdata[8:0] & MODE_MASK;
      if (wr_len)  len  <= bus_wdata[LEN_W+4:5];
      if (wr_sub)  sub  <= bus_wdata[NSUB-1:0];
      if (load) begin
        cnt   <= reload;
        stage <= 1'b0;
      end else if (first) begin
        cnt   <= reload;
        stage <= 1'b1;
      end else if (mode[0] && tick && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (fire) begin
        pulse <= 1'b1;
        hold  <= '0;
      end
    end
  end

  assign irq     = stage && mode[3];
  assign sys_rst = pulse;
  assign ext_rst = (pulse && mode[2]) ? mode[1] : ~mode[1];
  assign sub_rst = sub;

  always_comb begin
    case (bus_addr)
      8'h00:   bus_rdata = {23'd0, mode};
      8'h04:   bus_rdata = {{(27 - LEN_W){1'b0}}, len, 5'h08};
      8'h18:   bus_rdata = {{(32 - NSUB){1'b0}}, sub};
      default: bus_rdata = '0;
    endcase
  end

  p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(tick) ||
      ($past(bus_we) && $past(bus_addr) == 8'h14 && $past(bus_wdata) == 32'h0000_1209));

  p_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h00 && bus_wdata[31:24] != 8'h22 && !sys_rst)
      |=> $stable(mode));

  p_kick_clears_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h08 && bus_wdata == 32'h0000_1971 && !sys_rst) |=> !irq);

  p_defaults_after_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (mode == 9'd0 && sub == '0 && !irq));

  p_sub_key_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h18 && bus_wdata[31:24] != 8'h88 && !sys_rst)
      |=> $stable(sub_rst));
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int LW = 6, UL = 2, HD = 4, NS = 4, LR = 5;
  localparam int U = 1 << UL;

  logic clk = 0, rst_n = 0, tick = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, sys_rst, ext_rst;
  logic [NS-1:0] sub_rst;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_wdt #(.LEN_W(LW), .UNIT_LOG(UL), .HOLD(HD), .NSUB(NS), .LEN_RST(LR)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sys_rst(sys_rst),
    .ext_rst(ext_rst), .sub_rst(sub_rst));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk) begin bus_we = 1; bus_addr = a; bus_wdata = d; end
    @(negedge clk) bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk) bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_pulse(input string req);
    ticks(HD - 1);
    chk(sys_rst == 1, req, sys_rst, 1);
    ticks(1);
    chk(sys_rst == 0, req, sys_rst, 0);
  endtask

  logic [31:0] d;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, d); chk(d == 0, "R1 mode", d, 0);
    rd(8'h04, d); chk(d == ((LR << 5) | 8), "R1 len", d, (LR << 5) | 8);
    rd(8'h18, d); chk(d == 0, "R1 sub", d, 0);
    chk({irq, sys_rst, ext_rst} == 3'b001, "R1 outputs", {irq, sys_rst, ext_rst}, 1);
    ticks(40);
    chk(sys_rst == 0, "R1 disabled no reset", sys_rst, 0);

    // R3 length key
    wr(8'h04, (3 << 5) | 9);
    rd(8'h04, d); chk(d == ((LR << 5) | 8), "R3 bad key", d, (LR << 5) | 8);
    wr(8'h04, (3 << 5) | 8);
    rd(8'h04, d); chk(d == ((3 << 5) | 8), "R3 good key", d, (3 << 5) | 8);

    // R2 mode key and field mask
    wr(8'h00, 32'h2100_0001);
    rd(8'h00, d); chk(d == 0, "R2 bad key", d, 0);
    wr(8'h00, 32'h2200_01B0);
    rd(8'h00, d); chk(d == 32'h110, "R2 mask", d, 32'h110);
    wr(8'h00, 32'h2200_0000);

    // R11 sub-reset
    wr(8'h18, 32'h8800_000A);
    chk(sub_rst == 4'hA, "R11 drive", sub_rst, 4'hA);
    rd(8'h18, d); chk(d == 32'hA, "R11 read", d, 32'hA);
    wr(8'h18, 32'h8700_0005);
    chk(sub_rst == 4'hA, "R11 bad key", sub_rst, 4'hA);

    // R4/R9/R10 sweep over lengths with alternating polarity
    for (int L = 1; L <= 12; L++) begin
      logic pol;
      pol = L[0];
      wr(8'h18, 32'h8800_0005);
      wr(8'h04, (L << 5) | 8);
      wr(8'h00, 32'h2200_0005 | (32'(pol) << 1));
      ticks(L * U - 1);
      chk(sys_rst == 0, "R4 early", sys_rst, 0);
      chk(ext_rst == !pol, "R10 idle", ext_rst, !pol);
      ticks(1);
      chk(sys_rst == 1, "R4 expiry", sys_rst, 1);
      chk(ext_rst == pol, "R10 active", ext_rst, pol);
      wr(8'h18, 32'h8800_000A);
      rd(8'h18, d); chk(d == 5, "R9 write ignored", d, 5);
      finish_pulse("R9 hold");
      rd(8'h00, d); chk(d == 0, "R9 mode default", d, 0);
      rd(8'h04, d); chk(d == ((LR << 5) | 8), "R9 len default", d, (LR << 5) | 8);
      chk(sub_rst == 0, "R9 sub default", sub_rst, 0);
      chk(ext_rst == 1, "R10 default idle", ext_rst, 1);
    end

    // R5 restart key
    wr(8'h04, (4 << 5) | 8); wr(8'h00, 32'h2200_0001);
    ticks(10); wr(8'h08, 32'h1970); ticks(5);
    chk(sys_rst == 0, "R5 wrong code early", sys_rst, 0);
    ticks(1); chk(sys_rst == 1, "R5 wrong code no effect", sys_rst, 1);
    finish_pulse("R9 hold");
    wr(8'h04, (4 << 5) | 8); wr(8'h00, 32'h2200_0001);
    ticks(10); wr(8'h08, 32'h1971); ticks(15);
    chk(sys_rst == 0, "R5 reload", sys_rst, 0);
    ticks(1); chk(sys_rst == 1, "R5 reload expiry", sys_rst, 1);
    finish_pulse("R9 hold");

    // R3 length write does not restart
    wr(8'h04, (4 << 5) | 8); wr(8'h00, 32'h2200_0001);
    ticks(10); wr(8'h04, (8 << 5) | 8); ticks(5);
    chk(sys_rst == 0, "R3 no reload early", sys_rst, 0);
    ticks(1); chk(sys_rst == 1, "R3 no reload", sys_rst, 1);
    finish_pulse("R9 hold");

    // R6 two-stage sweep
    for (int L = 1; L <= 6; L++) begin
      wr(8'h04, (L << 5) | 8); wr(8'h00, 32'h2200_0049);
      ticks(L * U - 1);
      chk(irq == 0, "R6 irq early", irq, 0);
      ticks(1);
      chk(irq == 1 && sys_rst == 0, "R6 first stage", {irq, sys_rst}, 2);
      ticks(L * U - 1);
      chk(sys_rst == 0 && irq == 1, "R6 hold irq", {irq, sys_rst}, 2);
      ticks(1);
      chk(sys_rst == 1, "R6 second stage", sys_rst, 1);
      finish_pulse("R9 hold");
    end

    // R7 irq clearing paths
    wr(8'h04, (2 << 5) | 8); wr(8'h00, 32'h2200_0049);
    ticks(8); chk(irq == 1, "R7 raise", irq, 1);
    wr(8'h08, 32'h1971); chk(irq == 0, "R7 restart clears", irq, 0);
    ticks(7); chk(irq == 0, "R7 re-arm early", irq, 0);
    ticks(1); chk(irq == 1, "R7 re-raise", irq, 1);
    wr(8'h00, 32'h2200_0041); chk(irq == 0, "R7 disable clears", irq, 0);
    ticks(7); chk(sys_rst == 0, "R7 early", sys_rst, 0);
    ticks(1); chk(sys_rst == 1, "R7 reset after disable", sys_rst, 1);
    finish_pulse("R9 hold");

    // R8 software reset
    wr(8'h14, 32'h1208); chk(sys_rst == 0, "R8 wrong code", sys_rst, 0);
    wr(8'h14, 32'h1209); chk(sys_rst == 1, "R8 fire", sys_rst, 1);
    finish_pulse("R8 hold");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule